// File: doc/BRIEF.md
# Two-Output Level Interrupt Controller

This block gathers up to 31 level-sensitive interrupt request lines from peripherals and presents them to a CPU as two interrupt outputs. Each source has an enable bit. Software never writes the enable mask as a whole. It sets bits by writing ones to a set register, and it clears bits by writing ones to a clear register. A per-source steering bit selects which of the two CPU outputs the source drives. The top bit of the enable mask is a master switch that gates both outputs.

Software reads three kinds of status. The raw status shows the synchronized input lines with no enable or steering applied. Each output also has its own masked status. Every request line passes through a two-flop synchronizer first. Each CPU output is the OR of its masked status, taken through one flop. The register bus is a single-cycle synchronous port: writes are captured on the clock edge, and read data is a combinational function of the address.

Top module: `intc_dual_top`

## Requirements
- R1: After reset the enable mask and steering register are all zero, both CPU outputs are low, and every mapped offset reads 0.
- R2: A write to byte offset 0x34 sets each enable bit whose data bit is 1. Every other enable bit keeps its value.
- R3: A write to byte offset 0x38 clears each enable bit whose data bit is 1. Every other enable bit keeps its value.
- R4: Enable bit 31 is the master enable. While it is 0, both CPU outputs stay low and both masked status words read 0.
- R5: Steering is set at byte offset 0x20, which holds one bit per source in bits 30..0; bit 31 reads 0. A steering bit of 0 sends that source to cpuIrq0, with status at 0x00. A steering bit of 1 sends it to cpuIrq1, with status at 0x04.
- R6: Masked status for an output is raw AND enable AND steering-selects-that-output, with bit 31 reading 0. A bit stays set for as long as its line is high and the source is enabled. No acknowledge exists.
- R7: Raw status at 0x30 shows the request lines after a two-flop synchronizer, ignoring enable and steering. Bit 31 reads 0.
- R8: Each CPU output is the OR of its masked status, registered once. A line that rises while its source is enabled raises the output on the third clock edge after the change.
- R9: Reads of 0x34 and 0x38 both return the current enable mask, including bit 31.
- R10: Any offset other than 0x00, 0x04, 0x20, 0x30, 0x34 and 0x38 reads 0. A write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 31 | Level-sensitive request lines, asynchronous to clk |
| busAddr | input | 8 | Byte offset of register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| cpuIrq0 | output | 1 | CPU interrupt output 0 |
| cpuIrq1 | output | 1 | CPU interrupt output 1 |

## Verification
The enable assertions assume that one write strobe decodes to at most one register. They also assume that write data is stable in the cycle the strobe is high. The bench holds busAddr, busWe and busWdata steady from one falling edge to the next and issues single writes. The routing assertions look one cycle back and assume the output flop has seen at least one edge since reset. Request lines are changed only at falling edges, so the synchronizer never sees an ambiguous sample. Random stimulus mixes set, clear, steering and unmapped writes with request changes, and the bench waits past the three-flop latency before comparing against its model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_STAT0 = 'h00;
  localparam int OFF_STAT1 = 'h04;
  localparam int OFF_TYPE  = 'h20;
  localparam int OFF_RAW   = 'h30;
  localparam int OFF_ESET  = 'h34;
  localparam int OFF_ECLR  = 'h38;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT0, RD_STAT1, RD_TYPE, RD_RAW, RD_EN
  } rdSel_e;

  typedef struct packed {
    logic   wrSet;
    logic   wrClr;
    logic   wrType;
    rdSel_e rdSel;
  } regStrb_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrb_t          strb
);
  always_comb begin
    strb = '{wrSet: 1'b0, wrClr: 1'b0, wrType: 1'b0, rdSel: RD_NONE};
    if (busAddr == ADDR_W'(OFF_STAT0)) begin
      strb.rdSel = RD_STAT0;
    end else if (busAddr == ADDR_W'(OFF_STAT1)) begin
      strb.rdSel = RD_STAT1;
    end else if (busAddr == ADDR_W'(OFF_TYPE)) begin
      strb.rdSel  = RD_TYPE;
      strb.wrType = busWe;
    end else if (busAddr == ADDR_W'(OFF_RAW)) begin
      strb.rdSel = RD_RAW;
    end else if (busAddr == ADDR_W'(OFF_ESET)) begin
      strb.rdSel = RD_EN;
      strb.wrSet = busWe;
    end else if (busAddr == ADDR_W'(OFF_ECLR)) begin
      strb.rdSel = RD_EN;
      strb.wrClr = busWe;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-2:0]     irqIn,
  input  regStrb_t              strb,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  cpuIrq0,
  output logic                  cpuIrq1
);
  localparam int NUM_SRC = DATA_W - 1;
  localparam int GLB     = DATA_W - 1;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [DATA_W-1:0]  enMask;
  logic [NUM_SRC-1:0] typeReg;
  logic [NUM_SRC-1:0] rawLines, maskQ0, maskQ1;
  logic               globalOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign rawLines = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= '0;
      typeReg <= '0;
    end else begin
      if (strb.wrSet)  enMask  <= enMask | wrData;
      if (strb.wrClr)  enMask  <= enMask & ~wrData;
      if (strb.wrType) typeReg <= wrData[NUM_SRC-1:0];
    end
  end

  assign globalOn = enMask[GLB];
  assign maskQ0   = globalOn ? (rawLines & enMask[NUM_SRC-1:0] & ~typeReg) : '0;
  assign maskQ1   = globalOn ? (rawLines & enMask[NUM_SRC-1:0] & typeReg)  : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuIrq0 <= 1'b0;
      cpuIrq1 <= 1'b0;
    end else begin
      cpuIrq0 <= |maskQ0;
      cpuIrq1 <= |maskQ1;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STAT0: rdData = {1'b0, maskQ0};
      RD_STAT1: rdData = {1'b0, maskQ1};
      RD_TYPE:  rdData = {1'b0, typeReg};
      RD_RAW:   rdData = {1'b0, rawLines};
      RD_EN:    rdData = enMask;
      default:  rdData = '0;
    endcase
  end

  // R2: set write raises the requested bits and leaves the others
  p_set_hits_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((enMask & $past(wrData)) == $past(wrData)));
  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> (((enMask ^ $past(enMask)) & ~$past(wrData)) == '0));
  // R3: clear write drops the requested bits and leaves the others
  p_clr_hits_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((enMask & $past(wrData)) == '0));
  p_clr_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> (((enMask ^ $past(enMask)) & ~$past(wrData)) == '0));
  // R4: master enable off keeps both outputs low on the next edge
  p_global_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enMask[GLB] |=> (!cpuIrq0 && !cpuIrq1));
  // R5: an output is only raised by a source steered to it
  p_route0_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq0 |-> $past(|(enMask[NUM_SRC-1:0] & ~typeReg)));
  p_route1_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq1 |-> $past(|(enMask[NUM_SRC-1:0] & typeReg)));
endmodule

// File: rtl/intc_dual_top.sv
module intc_dual_top
  import intc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-2:0] irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              cpuIrq0,
  output logic              cpuIrq1
);
  regStrb_t strb;

  intc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  intc_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strb   (strb),
    .wrData (busWdata),
    .rdData (busRdata),
    .cpuIrq0(cpuIrq0),
    .cpuIrq1(cpuIrq1)
  );
endmodule

// File: tb/tb_intc_dual_top.sv
module tb_intc_dual_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [30:0] irqIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cpuIrq0, cpuIrq1;

  int total = 0;
  int bad = 0;
  logic [31:0] mEn = '0;
  logic [30:0] mType = '0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  intc_dual_top dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cpuIrq0(cpuIrq0), .cpuIrq1(cpuIrq1)
  );

  function automatic logic [31:0] expMask(input logic sel);
    logic [30:0] route = sel ? mType : ~mType;
    return mEn[31] ? {1'b0, irqIn & mEn[30:0] & route} : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    if (a == 8'h34) mEn = mEn | d;
    else if (a == 8'h38) mEn = mEn & ~d;
    else if (a == 8'h20) mType = d[30:0];
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    busRead(8'h00, rd); check({tag, " R6 stat0"}, rd, expMask(1'b0));
    busRead(8'h04, rd); check({tag, " R5 stat1"}, rd, expMask(1'b1));
    busRead(8'h30, rd); check({tag, " R7 raw"}, rd, {1'b0, irqIn});
    busRead(8'h34, rd); check({tag, " R9 en"}, rd, mEn);
    busRead(8'h20, rd); check({tag, " R5 type"}, rd, {1'b0, mType});
    check({tag, " R8 irq0"}, {31'h0, cpuIrq0}, {31'h0, |expMask(1'b0)});
    check({tag, " R8 irq1"}, {31'h0, cpuIrq1}, {31'h0, |expMask(1'b1)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    irqIn = 31'h7fff_ffff;
    settle();
    // R1: reset state, all inputs high but nothing enabled
    busRead(8'h34, rd); check("R1 en", rd, 32'h0);
    busRead(8'h20, rd); check("R1 type", rd, 32'h0);
    busRead(8'h00, rd); check("R1 stat0", rd, 32'h0);
    check("R1 irq", {30'h0, cpuIrq1, cpuIrq0}, 32'h0);

    // R4: all sources enabled, master off
    busWrite(8'h34, 32'h7fff_ffff); settle();
    check("R4 irq", {30'h0, cpuIrq1, cpuIrq0}, 32'h0);
    busRead(8'h04, rd); check("R4 stat1", rd, 32'h0);
    busRead(8'h00, rd); check("R4 stat0", rd, 32'h0);

    // R2/R3: set and clear leave untouched bits alone
    busWrite(8'h38, 32'hffff_ffff);
    busWrite(8'h34, 32'h0000_00f0);
    busWrite(8'h34, 32'h8000_0003);
    busRead(8'h38, rd); check("R2 set", rd, 32'h8000_00f3);
    busWrite(8'h38, 32'h0000_0021);
    busRead(8'h34, rd); check("R3 clr", rd, 32'h8000_00d2);

    // R10: unmapped write ignored, unmapped read zero
    busWrite(8'h08, 32'hffff_ffff);
    busWrite(8'h36, 32'hffff_ffff);
    busRead(8'h34, rd); check("R10 en kept", rd, 32'h8000_00d2);
    busRead(8'h20, rd); check("R10 type kept", rd, 32'h0);
    busRead(8'h10, rd); check("R10 read zero", rd, 32'h0);

    // R8: latency from line rise to output
    irqIn = '0; settle();
    busWrite(8'h20, 32'h0000_0080);
    @(negedge clk); irqIn = 31'h0000_0080;
    @(negedge clk); @(negedge clk);
    check("R8 not yet", {31'h0, cpuIrq1}, 32'h0);
    busAddr = 8'h30; #1 check("R7 raw sync", busRdata, 32'h0000_0080);
    @(negedge clk);
    check("R8 third edge", {31'h0, cpuIrq1}, 32'h1);
    check("R5 route1 only", {31'h0, cpuIrq0}, 32'h0);
    // R6: level held, stays set with no acknowledge
    repeat (10) @(negedge clk);
    busRead(8'h04, rd); check("R6 level held", rd, 32'h0000_0080);
    irqIn = 31'h4000_0000; settle();
    busRead(8'h30, rd); check("R7 bit30 raw", rd, 32'h4000_0000);
    checkAll("dir");

    for (int i = 0; i < 250; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: busWrite(8'h34, $urandom);
        1: busWrite(8'h38, $urandom & 32'h7fff_ffff);
        2: busWrite(8'h20, $urandom);
        3: busWrite(8'(4 * $urandom_range(2, 7)), $urandom);
        default: begin @(negedge clk); irqIn = 31'($urandom); end
      endcase
      if (i % 16 == 15) busWrite(8'h34, 32'h8000_0000);
      settle();
      checkAll("rnd");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule